// File: doc/BRIEF.md
# Voltage Channel Mode and Inversion Control

This block holds the mode register for four analog-sense channels and applies each channel's configured transform to its 8-bit measured samples before they are shown and compared against limits. Channels 1 to 3 share their sensor pins with diode measurements. An enable bit per channel switches that channel from diode mode into voltage mode. This voltage mode takes precedence over any separate diode-pairing setting, and that precedence is reported on `volt_mode`. Channel 4 is a dedicated voltage input and is always in voltage mode. Each of the four channels has an invert bit. When that bit is set, the value the channel presents is full scale (FFh) minus the sample.

A host writes the register through `wr_en`/`wr_data` and reads it back on `rd_data`. Two interlocks limit those writes. Raising `sw_lock` freezes the register until the next reset. While `trip_mode` is high, the channel-1 enable bit, the channel-1 invert bit and the channel-4 invert bit are forced to zero. A small state machine in the register holds the lock: `CFG_OPEN` moves to `CFG_LOCKED` on the transition *lock_seen* and stays there until reset. Each channel lane has its own state machine. `LN_DIODE` moves to `LN_VOLT` on the transition *enable_set*, and `LN_VOLT` returns to `LN_DIODE` on *enable_cleared*. Channel 4 resets directly into `LN_VOLT`.

Top module: `vchan_xform_top`

## Requirements
- R1: After reset, `rd_data` is 00h, `xf_data`, `xf_vld`, `hi_flag` and `lo_flag` are zero, and `volt_mode` is 4'b1000, with only channel 4 in voltage mode.
- R2: The register bit map is as follows. Bit 0 is channel-1 invert, bit 1 is channel-1 enable, bit 2 is channel-2 invert, bit 3 is channel-2 enable, bit 4 is channel-3 invert, bit 5 is channel-3 enable and bit 6 is channel-4 invert. Bit 7 reads 0 and ignores writes, so writing FFh reads back 7Fh.
- R3: The transformed value of a channel whose invert bit is set is FFh minus its sample. A channel whose invert bit is clear passes its sample unchanged. This holds in both diode and voltage mode.
- R4: `xf_vld[n]` pulses high exactly one clock after `smp_vld[n]`, and `xf_data` byte n updates in that same clock.
- R5: A channel in voltage mode sets its `hi_flag` when its transformed value is strictly greater than its high limit (unsigned 8-bit).
- R6: A channel in voltage mode sets its `lo_flag` when its transformed value is less than or equal to its low limit (unsigned 8-bit).
- R7: A channel in diode mode raises neither flag. Its flags clear one clock after it enters or stays in diode mode.
- R8: While `trip_mode` is high, bits 0, 1 and 6 are stored as 0 on a write and read back 0, and channel 1 is neither inverted nor in voltage mode.
- R9: Once `sw_lock` has been high in any clock, host writes have no effect until reset. This includes a write in that same clock.
- R10: `volt_mode[n]` follows the channel's enable bit one clock after the register changes. Channel 4 is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the mode register |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Effective register contents |
| sw_lock | input | 1 | Software lock request, sticky until reset |
| trip_mode | input | 1 | Shared pin is used for the trip setting |
| smp_vld | input | 4 | Per-channel sample strobe |
| smp_data | input | 32 | Per-channel samples, byte n for channel n+1 |
| hi_lim | input | 32 | Per-channel high limits |
| lo_lim | input | 32 | Per-channel low limits |
| xf_data | output | 32 | Per-channel transformed values |
| xf_vld | output | 4 | Per-channel update pulse |
| hi_flag | output | 4 | Above-high-limit flags |
| lo_flag | output | 4 | At-or-below-low-limit flags |
| volt_mode | output | 4 | Per-channel voltage-mode indication |

## Verification
A corrupted mode register appears on `rd_data` in the clock after the write. It also shows in the next transformed sample of the affected channel, either as a missing or spurious FFh-minus result or as a flag pattern that does not match diode or voltage mode. A lane state that disagrees with its enable bit shows on `volt_mode` one clock later. It also shows as flags that appear in diode mode or fail to appear in voltage mode at the next sample. A lock state machine that fails to latch shows in the first write after `sw_lock` through a changed `rd_data`.

// File: rtl/vchan_pkg.sv
package vchan_pkg;
    localparam int CH_N = 4;
    localparam int DW   = 8;

    // bits blocked while the trip-setting pin mode is active
    localparam logic [DW-1:0] TRIP_BLOCK = 8'h43;
    // implemented bits (bit 7 unused)
    localparam logic [DW-1:0] IMPL_MASK  = 8'h7F;

    typedef enum logic {CFG_OPEN, CFG_LOCKED} cfg_st_e;
    typedef enum logic {LN_DIODE, LN_VOLT}    lane_st_e;

    function automatic int inv_pos(input int ch);
        return 2 * ch;
    endfunction

    function automatic int en_pos(input int ch);
        return 2 * ch + 1;
    endfunction
endpackage

// File: rtl/vchan_cfg_reg.sv
module vchan_cfg_reg
    import vchan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                sw_lock,
    input  logic                trip_mode,
    output logic [DW-1:0]       rd_data,
    output logic [CH_N-1:0]     inv,
    output logic [CH_N-2:0]     en
);
    cfg_st_e       state_q, state_d;
    logic [DW-1:0] cfg_q;
    logic [DW-1:0] block_m;
    logic [DW-1:0] eff;
    logic          wr_ok;

    assign block_m = trip_mode ? TRIP_BLOCK : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN:   if (sw_lock) state_d = CFG_LOCKED;
            CFG_LOCKED: state_d = CFG_LOCKED;
        endcase
    end

    assign wr_ok = wr_en && !sw_lock && (state_q == CFG_OPEN);

    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_ok) cfg_q <= wr_data & IMPL_MASK & ~block_m;
    end

    assign eff     = cfg_q & ~block_m;
    assign rd_data = eff;

    always_comb begin
        for (int c = 0; c < CH_N; c++) inv[c] = eff[inv_pos(c)];
        for (int c = 0; c < CH_N - 1; c++) en[c] = eff[en_pos(c)];
    end

    // R9: register frozen once locked
    a_r9_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_LOCKED) |=> $stable(cfg_q));
    // R9: the lock never releases before reset
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_LOCKED) |=> (state_q == CFG_LOCKED));
    // R8: blocked bits read zero in trip mode
    a_r8_trip_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trip_mode |-> ((rd_data & TRIP_BLOCK) == '0));
endmodule

// File: rtl/vchan_lane.sv
module vchan_lane
    import vchan_pkg::*;
#(
    parameter bit RESET_VOLT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          inv,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp,
    input  logic [DW-1:0] hi_lim,
    input  logic [DW-1:0] lo_lim,
    output logic [DW-1:0] xf,
    output logic          xf_vld,
    output logic          hi,
    output logic          lo,
    output logic          volt
);
    localparam logic [DW-1:0] FULL = '1;
    localparam lane_st_e RST_ST = RESET_VOLT ? LN_VOLT : LN_DIODE;

    lane_st_e      state_q, state_d;
    logic [DW-1:0] val;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_DIODE: if (en)  state_d = LN_VOLT;
            LN_VOLT:  if (!en) state_d = LN_DIODE;
        endcase
    end

    assign val  = inv ? (FULL - smp) : smp;
    assign volt = (state_q == LN_VOLT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xf     <= '0;
            xf_vld <= 1'b0;
            hi     <= 1'b0;
            lo     <= 1'b0;
        end else begin
            xf_vld <= smp_vld;
            if (smp_vld) xf <= val;
            unique case (state_q)
                LN_DIODE: begin
                    hi <= 1'b0;
                    lo <= 1'b0;
                end
                LN_VOLT: if (smp_vld) begin
                    hi <= (val > hi_lim);
                    lo <= (val <= lo_lim);
                end
            endcase
        end
    end

    // R4: strobe produces exactly one update pulse one clock later
    a_r4_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> xf_vld);
    a_r4_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !xf_vld);
    // R7: diode mode clears the flags
    a_r7_diode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_DIODE) |=> (!hi && !lo));
    // R4: value holds between strobes
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(xf));
endmodule

// File: rtl/vchan_xform_top.sv
module vchan_xform_top
    import vchan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    input  logic               sw_lock,
    input  logic               trip_mode,
    input  logic [CH_N-1:0]    smp_vld,
    input  logic [CH_N*DW-1:0] smp_data,
    input  logic [CH_N*DW-1:0] hi_lim,
    input  logic [CH_N*DW-1:0] lo_lim,
    output logic [CH_N*DW-1:0] xf_data,
    output logic [CH_N-1:0]    xf_vld,
    output logic [CH_N-1:0]    hi_flag,
    output logic [CH_N-1:0]    lo_flag,
    output logic [CH_N-1:0]    volt_mode
);
    logic [CH_N-1:0] inv;
    logic [CH_N-2:0] en_cfg;
    logic [CH_N-1:0] lane_en;

    vchan_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sw_lock   (sw_lock),
        .trip_mode (trip_mode),
        .rd_data   (rd_data),
        .inv       (inv),
        .en        (en_cfg)
    );

    // last channel is a dedicated voltage input
    assign lane_en = {1'b1, en_cfg};

    for (genvar g = 0; g < CH_N; g++) begin : g_lane
        vchan_lane #(.RESET_VOLT(g == CH_N - 1)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (lane_en[g]),
            .inv    (inv[g]),
            .smp_vld(smp_vld[g]),
            .smp    (smp_data[g*DW +: DW]),
            .hi_lim (hi_lim[g*DW +: DW]),
            .lo_lim (lo_lim[g*DW +: DW]),
            .xf     (xf_data[g*DW +: DW]),
            .xf_vld (xf_vld[g]),
            .hi     (hi_flag[g]),
            .lo     (lo_flag[g]),
            .volt   (volt_mode[g])
        );
    end
endmodule

// File: tb/vchan_xform_top_tb_top.sv
module vchan_xform_top_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_data = 0;
    logic [7:0]  rd_data;
    logic        sw_lock = 0;
    logic        trip_mode = 0;
    logic [3:0]  smp_vld = 0;
    logic [31:0] smp_data = 0;
    logic [31:0] hi_lim = {4{8'h80}};
    logic [31:0] lo_lim = {4{8'h20}};
    logic [31:0] xf_data;
    logic [3:0]  xf_vld, hi_flag, lo_flag, volt_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vchan_xform_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sw_lock(sw_lock), .trip_mode(trip_mode),
        .smp_vld(smp_vld), .smp_data(smp_data), .hi_lim(hi_lim),
        .lo_lim(lo_lim), .xf_data(xf_data), .xf_vld(xf_vld),
        .hi_flag(hi_flag), .lo_flag(lo_flag), .volt_mode(volt_mode)
    );

    // {ch[1:0], cfg, sample, exp value, exp hi, exp lo}; limits hi 80h, lo 20h
    localparam logic [27:0] VEC [12] = '{
        {2'd0, 8'h01, 8'h30, 8'hCF, 1'b0, 1'b0},
        {2'd0, 8'h03, 8'h30, 8'hCF, 1'b1, 1'b0},
        {2'd0, 8'h02, 8'h30, 8'h30, 1'b0, 1'b0},
        {2'd1, 8'h08, 8'h20, 8'h20, 1'b0, 1'b1},
        {2'd1, 8'h0C, 8'hDF, 8'h20, 1'b0, 1'b1},
        {2'd1, 8'h08, 8'h80, 8'h80, 1'b0, 1'b0},
        {2'd1, 8'h08, 8'h81, 8'h81, 1'b1, 1'b0},
        {2'd2, 8'h30, 8'h00, 8'hFF, 1'b1, 1'b0},
        {2'd2, 8'h10, 8'h00, 8'hFF, 1'b0, 1'b0},
        {2'd3, 8'h00, 8'h55, 8'h55, 1'b0, 1'b0},
        {2'd3, 8'h40, 8'h55, 8'hAA, 1'b1, 1'b0},
        {2'd3, 8'h40, 8'hFF, 8'h00, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
        @(negedge clk);
    endtask

    task automatic sample(input int ch, input logic [7:0] s);
        smp_data[ch*8 +: 8] = s;
        smp_vld[ch] = 1'b1;
        @(negedge clk);
        smp_vld = '0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 rd", {24'h0, rd_data}, 32'h00);
        check("R1 xf", xf_data, 32'h0);
        check("R1 flags", {20'h0, xf_vld, hi_flag, lo_flag}, 32'h0);
        check("R1 volt", {28'h0, volt_mode}, 32'h8);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 12; i++) begin
            automatic int ch = int'(VEC[i][27:26]);
            write_cfg(VEC[i][25:18]);
            check("R2 readback", {24'h0, rd_data}, {24'h0, VEC[i][25:18]});
            sample(ch, VEC[i][17:10]);
            check("R4 vld pulse", {28'h0, xf_vld}, 32'h1 << ch);
            check("R3 value", {24'h0, xf_data[ch*8 +: 8]}, {24'h0, VEC[i][9:2]});
            check("R5 hi", {31'h0, hi_flag[ch]}, {31'h0, VEC[i][1]});
            check("R6 lo", {31'h0, lo_flag[ch]}, {31'h0, VEC[i][0]});
            @(negedge clk);
            check("R4 pulse ends", {28'h0, xf_vld}, 32'h0);
        end

        // R2 bit 7 unused
        write_cfg(8'hFF);
        check("R2 bit7", {24'h0, rd_data}, 32'h7F);
        check("R10 volt all", {28'h0, volt_mode}, 32'hF);
        // R7 diode clears flags after leaving voltage mode
        write_cfg(8'h00);
        check("R10 volt diode", {28'h0, volt_mode}, 32'h8);
        check("R7 flags clear", {29'h0, hi_flag[2:0]} | {29'h0, lo_flag[2:0]}, 32'h0);

        // R8 trip mode interlock
        trip_mode = 1;
        write_cfg(8'h7F);
        check("R8 readback", {24'h0, rd_data}, 32'h3C);
        check("R8 ch1 mode", {31'h0, volt_mode[0]}, 32'h0);
        sample(0, 8'h30);
        check("R8 ch1 not inverted", {24'h0, xf_data[7:0]}, 32'h30);
        trip_mode = 0;
        @(negedge clk);
        check("R8 stored zero", {24'h0, rd_data}, 32'h3C);

        // R9 lock, write in same cycle as lock is ignored
        write_cfg(8'h00);
        @(negedge clk); sw_lock = 1; wr_en = 1; wr_data = 8'h55;
        @(negedge clk); sw_lock = 0; wr_en = 0;
        check("R9 same-cycle", {24'h0, rd_data}, 32'h00);
        write_cfg(8'h7F);
        check("R9 locked", {24'h0, rd_data}, 32'h00);
        sample(0, 8'h30);
        check("R9 no invert", {24'h0, xf_data[7:0]}, 32'h30);

        // R1 reset clears the lock
        rst_n = 0;
        @(negedge clk); rst_n = 1;
        write_cfg(8'h01);
        check("R1 lock cleared", {24'h0, rd_data}, 32'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule